// File: doc/BRIEF.md
# Programmable Tap Delay Line

This block delays a single-bit signal by a programmable number of sample-clock cycles. The total delay is a fixed minimum latency plus a step count. One step is one clock cycle. The step count comes from a 10-bit binary select word. Typical uses are aligning several sampled channels against a reference, or trimming the timing of a strobe in a clock-domain model.

The select word and an extra cascade bit pass through a holding stage. While `lock` is low, the holding stage is transparent and the delay follows `sel` in the same cycle. While `lock` is high, the value seen on the last cycle with `lock` low is kept. Two override inputs force the step count to zero or to full scale, and the held value takes on the forced setting. The cascade bit drives a complementary output pair. This pair can set the overrides of a following delay line and so extend the range. A `mute` input forces the output low.

Top module: `tapdelay_line`

## Requirements
- R1: While `lock` is low and neither override is high, the step count used at a clock edge is the `sel` value present at that same edge.
- R2: While `lock` is high and neither override is high, the step count and cascade bit keep the value seen at the last edge where `lock` was low, and changes on `sel` and `casc_sel` have no effect.
- R3: When `force_min` is high, the step count is 0 and the cascade bit is 0, whatever `force_max`, `lock`, `sel` and `casc_sel` are.
- R4: When `force_max` is high and `force_min` is low, the step count is 2^SEL_W (1024 with defaults, one more than the all-ones code) and the cascade bit is 1.
- R5: An override also writes the held value, so after an override is released with `lock` still high, its setting stays in effect.
- R6: The delay is binary weighted: `sel` bit i adds 2^i steps (bit 0 is the LSB). A `din` value sampled at edge t appears on `dout` right after edge t + MIN_LAT + steps (MIN_LAT = 2 by default).
- R7: If `mute` is high at an edge, `dout` is low after that edge. Otherwise `dout` carries the delayed input.
- R8: After each edge, `casc_out` equals the cascade bit in use at that edge and `casc_out_n` is its complement.
- R9: A synchronous high `rst` clears the line, the held value and the outputs: `dout` = 0, `casc_out` = 0, `casc_out_n` = 1. Samples from before the reset never reach `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one cycle is one delay step |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Signal to be delayed |
| sel | input | SEL_W | Binary step count |
| casc_sel | input | 1 | Cascade bit, held with `sel` |
| lock | input | 1 | Low: transparent; high: hold |
| force_min | input | 1 | Force zero steps, cascade 0 (wins) |
| force_max | input | 1 | Force 2^SEL_W steps, cascade 1 |
| mute | input | 1 | High forces `dout` low |
| dout | output | 1 | Delayed signal, registered |
| casc_out | output | 1 | Cascade bit, registered |
| casc_out_n | output | 1 | Complement of `casc_out` |

## Verification
The bench uses SEL_W = 10 and MIN_LAT = 2, so the line is 1026 stages long. Runs of over 1100 cycles at the all-ones code and under `force_max` fill the whole line. This exercises the deepest tap and the extra step that full scale adds over code 1023. The short minimum latency also brings the shortest total delay of two cycles, with a freshly changed `sel`, into the random phase.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  // Source of the step count used in the current cycle, in priority order.
  typedef enum logic [1:0] {
    SRC_MIN  = 2'd0,
    SRC_MAX  = 2'd1,
    SRC_LIVE = 2'd2,
    SRC_HELD = 2'd3
  } sel_src_e;

  function automatic sel_src_e pick_src(input logic fmin, input logic fmax, input logic lock);
    if (fmin)       return SRC_MIN;
    else if (fmax)  return SRC_MAX;
    else if (!lock) return SRC_LIVE;
    else            return SRC_HELD;
  endfunction

endpackage

// File: rtl/tdl_sel_latch.sv
module tdl_sel_latch
  import tdl_pkg::*;
#(
  parameter int SEL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             casc_sel,
  input  logic             lock,
  input  logic             force_min,
  input  logic             force_max,
  output logic [SEL_W:0]   steps,
  output logic             casc
);

  localparam logic [SEL_W:0] FULL_SCALE = {1'b1, {SEL_W{1'b0}}};

  sel_src_e       src;
  logic [SEL_W:0] held_steps;
  logic           held_casc;

  always_comb src = pick_src(force_min, force_max, lock);

  // The count in use this cycle; overrides and the transparent path act at once.
  always_comb begin
    case (src)
      SRC_MIN:  begin steps = '0;            casc = 1'b0;      end
      SRC_MAX:  begin steps = FULL_SCALE;    casc = 1'b1;      end
      SRC_LIVE: begin steps = {1'b0, sel};   casc = casc_sel;  end
      default:  begin steps = held_steps;    casc = held_casc; end
    endcase
  end

  // The held copy follows whatever is not the held value itself, overrides included.
  always_ff @(posedge clk) begin
    if (rst) begin
      held_steps <= '0;
      held_casc  <= 1'b0;
    end else if (src != SRC_HELD) begin
      held_steps <= steps;
      held_casc  <= casc;
    end
  end

endmodule

// File: rtl/tdl_tap_line.sv
module tdl_tap_line #(
  parameter int DEPTH = 1026,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [IDX_W-1:0] idx,
  output logic             tap
);

  logic [DEPTH-1:0] line;

  // Stage 0 takes the new sample; each later stage takes its neighbour.
  always_ff @(posedge clk) begin
    if (rst) line <= '0;
    else     line <= {line[DEPTH-2:0], din};
  end

  always_comb tap = line[idx];

endmodule

// File: rtl/tdl_out_stage.sv
module tdl_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic tap,
  input  logic mute,
  input  logic casc,
  output logic dout,
  output logic casc_out,
  output logic casc_out_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= 1'b0;
      casc_out   <= 1'b0;
      casc_out_n <= 1'b1;
    end else begin
      dout       <= mute ? 1'b0 : tap;
      casc_out   <= casc;
      casc_out_n <= ~casc;
    end
  end

endmodule

// File: rtl/tapdelay_line.sv
module tapdelay_line #(
  parameter int SEL_W   = 10,
  parameter int MIN_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             casc_sel,
  input  logic             lock,
  input  logic             force_min,
  input  logic             force_max,
  input  logic             mute,
  output logic             dout,
  output logic             casc_out,
  output logic             casc_out_n
);

  localparam int MAX_STEPS = 1 << SEL_W;
  localparam int DEPTH     = MAX_STEPS + MIN_LAT;
  localparam int IDX_W     = $clog2(DEPTH);

  logic [SEL_W:0]   eff_steps;
  logic             eff_casc;
  logic [IDX_W-1:0] tap_idx;
  logic             tap;

  tdl_sel_latch #(.SEL_W(SEL_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .casc_sel  (casc_sel),
    .lock      (lock),
    .force_min (force_min),
    .force_max (force_max),
    .steps     (eff_steps),
    .casc      (eff_casc)
  );

  // The output register adds one cycle, so the tap sits one stage short of the total.
  assign tap_idx = IDX_W'(eff_steps) + IDX_W'(MIN_LAT - 1);

  tdl_tap_line #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_line (
    .clk (clk),
    .rst (rst),
    .din (din),
    .idx (tap_idx),
    .tap (tap)
  );

  tdl_out_stage u_out (
    .clk        (clk),
    .rst        (rst),
    .tap        (tap),
    .mute       (mute),
    .casc       (eff_casc),
    .dout       (dout),
    .casc_out   (casc_out),
    .casc_out_n (casc_out_n)
  );

endmodule

// File: rtl/tapdelay_line_chk.sv
module tapdelay_line_chk #(
  parameter int SEL_W = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           casc_sel,
  input logic           lock,
  input logic           force_min,
  input logic           force_max,
  input logic           mute,
  input logic           dout,
  input logic           casc_out,
  input logic           casc_out_n,
  input logic [SEL_W:0] eff_steps
);

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!dout && !casc_out && casc_out_n));

  assert_mute_low_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mute)) |-> !dout);

  assert_min_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_min)) |-> (!casc_out && casc_out_n));

  assert_max_casc_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_max && !force_min)) |-> (casc_out && !casc_out_n));

  assert_live_casc_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!force_min && !force_max && !lock)) |-> (casc_out == $past(casc_sel)));

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && lock && $past(lock) && !force_min && !force_max
     && !$past(force_min) && !$past(force_max)) |-> $stable(eff_steps));

endmodule

bind tapdelay_line tapdelay_line_chk #(.SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .casc_sel   (casc_sel),
  .lock       (lock),
  .force_min  (force_min),
  .force_max  (force_max),
  .mute       (mute),
  .dout       (dout),
  .casc_out   (casc_out),
  .casc_out_n (casc_out_n),
  .eff_steps  (eff_steps)
);

// File: tb/tapdelay_line_test.sv
`timescale 1ns/1ps
module tapdelay_line_test;

  localparam int SEL_W   = 10;
  localparam int MIN_LAT = 2;
  localparam int FULL    = 1 << SEL_W;
  localparam int HSZ     = 4096;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             din = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic             casc_sel = 1'b0;
  logic             lock = 1'b0;
  logic             force_min = 1'b0;
  logic             force_max = 1'b0;
  logic             mute = 1'b0;
  logic             dout, casc_out, casc_out_n;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R9";

  // Bench model state
  logic hist [0:HSZ-1];
  int   edge_n = 0;
  int   m_cap = 0;
  logic m_capc = 1'b0;
  logic exp_dout = 1'b0;
  logic exp_casc = 1'b0;

  always #10 clk = ~clk;

  tapdelay_line #(.SEL_W(SEL_W), .MIN_LAT(MIN_LAT)) uut (
    .clk(clk), .rst(rst), .din(din), .sel(sel), .casc_sel(casc_sel),
    .lock(lock), .force_min(force_min), .force_max(force_max), .mute(mute),
    .dout(dout), .casc_out(casc_out), .casc_out_n(casc_out_n)
  );

  function automatic logic past_din(input int k);
    if (k < 0) return 1'b0;
    return hist[k % HSZ];
  endfunction

  task automatic model_edge();
    int   st;
    logic cb;
    if (rst) begin
      m_cap = 0; m_capc = 1'b0;
      exp_dout = 1'b0; exp_casc = 1'b0;
      hist[edge_n % HSZ] = 1'b0;
    end else begin
      if (force_min)      begin st = 0;        cb = 1'b0;     end
      else if (force_max) begin st = FULL;     cb = 1'b1;     end
      else if (!lock)     begin st = int'(sel); cb = casc_sel; end
      else                begin st = m_cap;    cb = m_capc;   end
      if (force_min || force_max || !lock) begin m_cap = st; m_capc = cb; end
      exp_dout = mute ? 1'b0 : past_din(edge_n - (MIN_LAT + st));
      exp_casc = cb;
      hist[edge_n % HSZ] = din;
    end
    edge_n++;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (dout !== exp_dout || casc_out !== exp_casc || casc_out_n !== ~exp_casc) begin
      fails++;
      $display("FAIL %s cycle %0d: dout=%b casc=%b/%b expected dout=%b casc=%b/%b",
               cur_req, edge_n, dout, casc_out, casc_out_n, exp_dout, exp_casc, ~exp_casc);
    end
  endtask

  task automatic run(input int n, input bit rnd_din);
    for (int i = 0; i < n; i++) begin
      if (rnd_din) din = 1'($urandom % 2);
      step();
    end
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed_val;
    for (int i = 0; i < HSZ; i++) hist[i] = 1'b0;
    seed_val = $urandom(32'h5EED_0196);
    // R9: reset state, with inputs trying to disturb it
    cur_req = "R9";
    din = 1'b1; sel = 10'd3; casc_sel = 1'b1;
    run(3, 0);
    rst = 1'b0;
    din = 1'b0; casc_sel = 1'b0;
    // R9: no pre-reset sample leaks out
    run(10, 0);

    // R6: binary weighting across several codes, including the all-ones code
    cur_req = "R6";
    foreach (sel[b]) begin
      sel = SEL_W'(1) << b;
      run((b < 6) ? 90 : (1 << b) + 20, 1);
    end
    sel = 10'd0;    run(40, 1);
    sel = 10'd1023; run(1100, 1);

    // R1: transparent mode follows sel in real time
    cur_req = "R1";
    for (int i = 0; i < 300; i++) begin
      if (i % 5 == 0) sel = SEL_W'($urandom % 24);
      din = 1'($urandom % 2);
      step();
    end

    // R2: hold mode ignores sel and casc_sel
    cur_req = "R2";
    sel = 10'd7; casc_sel = 1'b1; step();
    lock = 1'b1;
    for (int i = 0; i < 200; i++) begin
      sel = SEL_W'($urandom); casc_sel = 1'($urandom % 2);
      din = 1'($urandom % 2);
      step();
    end

    // R3: force_min beats force_max and everything else
    cur_req = "R3";
    force_min = 1'b1; force_max = 1'b1; casc_sel = 1'b1;
    for (int i = 0; i < 60; i++) begin
      lock = 1'($urandom % 2); sel = SEL_W'($urandom);
      din = 1'($urandom % 2);
      step();
    end
    force_min = 1'b0; force_max = 1'b0; lock = 1'b0;

    // R4: full scale is one step beyond the all-ones code
    cur_req = "R4";
    force_max = 1'b1; sel = 10'd5; casc_sel = 1'b0;
    run(1100, 1);
    force_max = 1'b0;

    // R5: overrides write the held value; it stays after release under lock
    cur_req = "R5";
    sel = 10'd3; step();
    lock = 1'b1;
    force_max = 1'b1; step();
    force_max = 1'b0; sel = 10'd9;
    run(1100, 1);
    force_min = 1'b1; step();
    force_min = 1'b0; sel = 10'd600;
    run(60, 1);
    lock = 1'b0;

    // R7: mute forces the output low
    cur_req = "R7";
    sel = 10'd4;
    for (int i = 0; i < 200; i++) begin
      mute = 1'($urandom % 2);
      din = 1'b1;
      step();
    end
    mute = 1'b0;

    // R8: cascade pair follows the cascade bit through the holding stage
    cur_req = "R8";
    for (int i = 0; i < 100; i++) begin
      casc_sel = 1'($urandom % 2);
      lock = (i % 10) > 6;
      step();
    end
    lock = 1'b0;

    // R6: mixed random traffic on every control
    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      din = 1'($urandom % 2);
      if (r < 10) sel = SEL_W'($urandom % 40);
      casc_sel  = 1'($urandom % 2);
      lock      = (r % 7) < 3;
      force_min = (r == 50);
      force_max = (r == 51) || (r == 50);
      mute      = (r > 95);
      step();
    end

    // R9: reset in mid-run clears everything
    cur_req = "R9";
    rst = 1'b1; din = 1'b1; run(2, 0);
    rst = 1'b0; force_min = 1'b0; force_max = 1'b0; mute = 1'b0;
    lock = 1'b1;
    run(40, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule